// File: doc/BRIEF.md
# Jump Table Target Fetch Unit

This unit produces the branch destination for a compressed table-jump instruction. On a start pulse it takes an 8-bit entry index, the current value of the jump-table base register, the active register width (32 or 64 bits) and a permission verdict from the privileged state-enable logic. It checks the permission first and the table mode second. Only when both checks pass does it compute the entry address and issue a single read on a simple request/response memory port.

When the read completes, the unit returns the loaded entry with its least significant bit cleared. It can instead report an exception together with a 4-bit cause code. A pipeline front end starts the unit on a table-jump instruction. It waits for `done`, then either redirects to `target` or takes the trap given by `exc_cause`. One operation is in flight at a time, and a start that arrives while a read is outstanding is ignored.

Top module: `jtab_target_unit`

## Requirements
- R1: After reset, `done`, `exc`, `busy` and `mem_req` are all low.
- R2: If `perm_ok` is low when an idle unit sees `start`, then on the next cycle `done` and `exc` are high and `exc_cause` equals the `perm_cause` sampled with `start`. No memory request is issued. This check takes priority over the mode check.
- R3: If `perm_ok` is high and `tbl_reg[5:0]` is nonzero when an idle unit sees `start`, then on the next cycle `done` and `exc` are high, `exc_cause` is 2 (illegal instruction), and no memory request is issued.
- R4: In 32-bit width (`wide`=0), `mem_addr` is `(tbl_reg[31:0] & ~63) + idx*4`, kept to 32 bits and zero-extended, and `mem_size` is 0 (4-byte read).
- R5: In 64-bit width (`wide`=1), `mem_addr` is `(tbl_reg & ~63) + idx*8` and `mem_size` is 1 (8-byte read).
- R6: `mem_req` rises on the cycle after an accepted start. It stays high with `mem_addr` and `mem_size` unchanged until a cycle in which `mem_valid` is high, and it is low on the following cycle.
- R7: The cycle after `mem_valid` arrives with `mem_err` low, `done` is high, `exc` is low, and `target` holds the loaded data with bit 0 cleared. In 32-bit width this data is `mem_rdata[31:0]` zero-extended.
- R8: The cycle after `mem_valid` arrives with `mem_err` high, `done` and `exc` are high and `exc_cause` is 1 (instruction access fault).
- R9: A `start` seen while `busy` is high is ignored: `mem_addr` and `mem_size` are unchanged, and the operation ends with the outcome of the first start.
- R10: `done` is a one-cycle pulse per operation, `exc` is high only while `done` is high, and `busy` is high exactly while a read is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| idx | input | 8 | Table entry index |
| tbl_reg | input | 64 | Table base register: base in upper bits, mode in [5:0] |
| wide | input | 1 | 1 = 64-bit register width, 0 = 32-bit |
| perm_ok | input | 1 | State-enable permission granted |
| perm_cause | input | 4 | Cause to report when permission is denied |
| busy | output | 1 | A memory read is outstanding |
| mem_req | output | 1 | Read request, held until response |
| mem_addr | output | 64 | Entry address |
| mem_size | output | 1 | 0 = 4-byte read, 1 = 8-byte read |
| mem_valid | input | 1 | Read response present |
| mem_rdata | input | 64 | Read data |
| mem_err | input | 1 | Read response is an error |
| done | output | 1 | Operation finished (one-cycle pulse) |
| exc | output | 1 | Operation ended with an exception |
| exc_cause | output | 4 | Exception cause code |
| target | output | 64 | Jump target, valid with `done` and not `exc` |

## Verification
Random operations mix both widths and the full index range. Base values carry random upper bits and random mode bits, so the tests show whether the base is masked and whether the scale factor follows `wide`. Some operations use loaded words with bit 0 set and upper bits that must be removed in narrow mode, which shows whether the clear and zero-extension are applied per width. Directed cases separate the two check failures from each other and from a successful fetch. They include permission and mode failing together to test priority, index 0 and 255, an error response, and a second start during a pending read.

// File: rtl/jtab_pkg.sv
package jtab_pkg;
   localparam int CAUSE_W = 4;
   localparam logic [CAUSE_W-1:0] CAUSE_ACCESS  = 4'd1;
   localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL = 4'd2;

   typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_WAIT = 1'b1} jt_state_e;

   typedef struct packed {
      logic               fault;
      logic [CAUSE_W-1:0] cause;
   } jt_chk_t;
endpackage

// File: rtl/jtab_check.sv
module jtab_check
   import jtab_pkg::*;
#(
   parameter int XLEN   = 64,
   parameter int MODE_W = 6
) (
   input  logic               perm_ok,
   input  logic [CAUSE_W-1:0] perm_cause,
   input  logic [XLEN-1:0]    tbl_reg,
   output jt_chk_t            res
);
   // Permission verdict outranks the mode field.
   always_comb begin
      res.fault = 1'b0;
      res.cause = '0;
      if (!perm_ok) begin
         res.fault = 1'b1;
         res.cause = perm_cause;
      end else if (tbl_reg[MODE_W-1:0] != '0) begin
         res.fault = 1'b1;
         res.cause = CAUSE_ILLEGAL;
      end
   end
endmodule

// File: rtl/jtab_addr.sv
module jtab_addr #(
   parameter int XLEN   = 64,
   parameter int IDX_W  = 8,
   parameter int MODE_W = 6
) (
   input  logic [XLEN-1:0]  tbl_reg,
   input  logic [IDX_W-1:0] idx,
   input  logic             wide,
   output logic [XLEN-1:0]  addr,
   output logic             size
);
   localparam logic [XLEN-1:0] MODE_MASK = {{(XLEN-MODE_W){1'b0}}, {MODE_W{1'b1}}};

   logic [XLEN-1:0] base;
   logic [XLEN-1:0] idx_ext;

   assign base    = tbl_reg & ~MODE_MASK;
   assign idx_ext = {{(XLEN-IDX_W){1'b0}}, idx};

   generate
      if (XLEN == 64) begin : g_dual
         logic [31:0]     narrow_sum;
         logic [XLEN-1:0] wide_sum;
         assign narrow_sum = base[31:0] + {idx_ext[29:0], 2'b00};
         assign wide_sum   = base + {idx_ext[XLEN-4:0], 3'b000};
         assign addr = wide ? wide_sum : {32'd0, narrow_sum};
         assign size = wide;
      end else begin : g_narrow
         logic unused_wide;
         assign unused_wide = wide;
         assign addr = base + {idx_ext[XLEN-3:0], 2'b00};
         assign size = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/jtab_fmt.sv
module jtab_fmt #(
   parameter int XLEN = 64
) (
   input  logic [XLEN-1:0] rdata,
   input  logic            wide,
   output logic [XLEN-1:0] target
);
   generate
      if (XLEN == 64) begin : g_dual
         assign target = wide ? {rdata[63:1], 1'b0}
                              : {32'd0, rdata[31:1], 1'b0};
      end else begin : g_narrow
         logic unused_wide;
         assign unused_wide = wide;
         assign target = {rdata[XLEN-1:1], 1'b0};
      end
   endgenerate
endmodule

// File: rtl/jtab_target_unit.sv
module jtab_target_unit
   import jtab_pkg::*;
#(
   parameter int XLEN   = 64,
   parameter int IDX_W  = 8,
   parameter int MODE_W = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [IDX_W-1:0]   idx,
   input  logic [XLEN-1:0]    tbl_reg,
   input  logic               wide,
   input  logic               perm_ok,
   input  logic [CAUSE_W-1:0] perm_cause,
   output logic               busy,
   output logic               mem_req,
   output logic [XLEN-1:0]    mem_addr,
   output logic               mem_size,
   input  logic               mem_valid,
   input  logic [XLEN-1:0]    mem_rdata,
   input  logic               mem_err,
   output logic               done,
   output logic               exc,
   output logic [CAUSE_W-1:0] exc_cause,
   output logic [XLEN-1:0]    target
);
   initial begin
      assert (XLEN == 32 || XLEN == 64)
         else $error("jtab_target_unit: XLEN must be 32 or 64");
      assert (IDX_W >= 1 && IDX_W <= XLEN - 3)
         else $error("jtab_target_unit: IDX_W out of range");
      assert (MODE_W >= 1 && MODE_W < XLEN)
         else $error("jtab_target_unit: MODE_W out of range");
   end

   jt_chk_t         chk;
   logic [XLEN-1:0] addr_d;
   logic            size_d;
   logic [XLEN-1:0] fmt_tgt;
   logic            wide_eff;

   jt_state_e          state_q;
   logic [XLEN-1:0]    addr_q;
   logic               size_q;
   logic               done_q;
   logic               exc_q;
   logic [CAUSE_W-1:0] cause_q;
   logic [XLEN-1:0]    tgt_q;

   assign wide_eff = (XLEN == 64) ? wide : 1'b0;

   jtab_check #(.XLEN(XLEN), .MODE_W(MODE_W)) u_check (
      .perm_ok    (perm_ok),
      .perm_cause (perm_cause),
      .tbl_reg    (tbl_reg),
      .res        (chk)
   );

   jtab_addr #(.XLEN(XLEN), .IDX_W(IDX_W), .MODE_W(MODE_W)) u_addr (
      .tbl_reg (tbl_reg),
      .idx     (idx),
      .wide    (wide_eff),
      .addr    (addr_d),
      .size    (size_d)
   );

   // Width of the held request decides the formatting of the response.
   jtab_fmt #(.XLEN(XLEN)) u_fmt (
      .rdata  (mem_rdata),
      .wide   (size_q),
      .target (fmt_tgt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         size_q  <= 1'b0;
         done_q  <= 1'b0;
         exc_q   <= 1'b0;
         cause_q <= '0;
         tgt_q   <= '0;
      end else begin
         done_q  <= 1'b0;
         exc_q   <= 1'b0;
         cause_q <= '0;
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  if (chk.fault) begin
                     done_q  <= 1'b1;
                     exc_q   <= 1'b1;
                     cause_q <= chk.cause;
                     tgt_q   <= '0;
                  end else begin
                     state_q <= ST_WAIT;
                     addr_q  <= addr_d;
                     size_q  <= size_d;
                  end
               end
            end
            ST_WAIT: begin
               if (mem_valid) begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
                  if (mem_err) begin
                     exc_q   <= 1'b1;
                     cause_q <= CAUSE_ACCESS;
                     tgt_q   <= '0;
                  end else begin
                     tgt_q <= fmt_tgt;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy      = (state_q == ST_WAIT);
   assign mem_req   = (state_q == ST_WAIT);
   assign mem_addr  = addr_q;
   assign mem_size  = size_q;
   assign done      = done_q;
   assign exc       = exc_q;
   assign exc_cause = cause_q;
   assign target    = tgt_q;
endmodule

// File: rtl/jtab_sva.sv
module jtab_sva
   import jtab_pkg::*;
#(
   parameter int XLEN   = 64,
   parameter int IDX_W  = 8,
   parameter int MODE_W = 6
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start,
   input logic [XLEN-1:0]    tbl_reg,
   input logic               perm_ok,
   input logic [CAUSE_W-1:0] perm_cause,
   input logic               busy,
   input logic               mem_req,
   input logic [XLEN-1:0]    mem_addr,
   input logic               mem_size,
   input logic               mem_valid,
   input logic               mem_err,
   input logic               done,
   input logic               exc,
   input logic [CAUSE_W-1:0] exc_cause,
   input logic [XLEN-1:0]    target
);
   p_perm_fail_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && !perm_ok) |=>
         (done && exc && exc_cause == $past(perm_cause) && !mem_req));

   p_mode_fail_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && perm_ok && tbl_reg[MODE_W-1:0] != '0) |=>
         (done && exc && exc_cause == CAUSE_ILLEGAL && !mem_req));

   p_narrow_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_size) |-> (mem_addr[1:0] == 2'b00));

   p_wide_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_size) |-> (mem_addr[2:0] == 3'b000));

   p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_valid) |=>
         (mem_req && $stable(mem_addr) && $stable(mem_size)));

   p_req_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_valid) |=> (!mem_req && done));

   p_target_lsb_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !exc) |-> (target[0] == 1'b0));

   p_err_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_valid && mem_err) |=>
         (done && exc && exc_cause == CAUSE_ACCESS));

   p_exc_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      exc |-> done);

   p_no_done_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !done);
endmodule

bind jtab_target_unit jtab_sva #(.XLEN(XLEN), .IDX_W(IDX_W), .MODE_W(MODE_W)) u_sva (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .tbl_reg    (tbl_reg),
   .perm_ok    (perm_ok),
   .perm_cause (perm_cause),
   .busy       (busy),
   .mem_req    (mem_req),
   .mem_addr   (mem_addr),
   .mem_size   (mem_size),
   .mem_valid  (mem_valid),
   .mem_err    (mem_err),
   .done       (done),
   .exc        (exc),
   .exc_cause  (exc_cause),
   .target     (target)
);

// File: tb/sim_jtab_target_unit.sv
module sim_jtab_target_unit;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  idx = '0;
   logic [63:0] tbl_reg = '0;
   logic        wide = 1'b0;
   logic        perm_ok = 1'b1;
   logic [3:0]  perm_cause = '0;
   logic        busy, mem_req, mem_size, done, exc;
   logic [63:0] mem_addr, target;
   logic [3:0]  exc_cause;
   logic        mem_valid = 1'b0;
   logic [63:0] mem_rdata = '0;
   logic        mem_err = 1'b0;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   jtab_target_unit u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .idx(idx), .tbl_reg(tbl_reg),
      .wide(wide), .perm_ok(perm_ok), .perm_cause(perm_cause), .busy(busy),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_size(mem_size),
      .mem_valid(mem_valid), .mem_rdata(mem_rdata), .mem_err(mem_err),
      .done(done), .exc(exc), .exc_cause(exc_cause), .target(target)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] exp_addr(input logic [63:0] t, input logic [7:0] i,
                                            input logic w);
      logic [63:0] b;
      logic [31:0] n;
      b = t & ~64'h3f;
      n = b[31:0] + ({24'd0, i} << 2);
      return w ? (b + ({56'd0, i} << 3)) : {32'd0, n};
   endfunction

   function automatic logic [63:0] exp_tgt(input logic [63:0] d, input logic w);
      return w ? (d & ~64'h1) : {32'd0, d[31:1], 1'b0};
   endfunction

   // One operation; lat = response cycles after request, dbl = second start mid-flight
   task automatic run_op(input logic [7:0] i, input logic [63:0] t, input logic w,
                         input logic pok, input logic [3:0] pc,
                         input logic [63:0] d, input logic e,
                         input int lat, input bit dbl);
      logic [63:0] ea;
      @(negedge clk);
      idx = i; tbl_reg = t; wide = w; perm_ok = pok; perm_cause = pc; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (!pok) begin
         chk(done && exc && exc_cause == pc && !mem_req, "R2",
             {56'd0, done, exc, mem_req, 1'b0, exc_cause}, {56'd0, 3'b110, 1'b0, pc});
      end else if (t[5:0] != 6'd0) begin
         chk(done && exc && exc_cause == 4'd2 && !mem_req, "R3",
             {56'd0, done, exc, mem_req, 1'b0, exc_cause}, {56'h0, 8'b11000010});
      end else begin
         ea = exp_addr(t, i, w);
         chk(mem_req && busy && !done, "R6", {61'd0, mem_req, busy, done}, 64'd6);
         chk(mem_addr == ea, w ? "R5" : "R4", mem_addr, ea);
         chk(mem_size == w, w ? "R5" : "R4", {63'd0, mem_size}, {63'd0, w});
         for (int k = 0; k < lat; k++) begin
            if (dbl && k == 0) begin
               idx = ~i; wide = ~w; tbl_reg = t + 64'h1000; start = 1'b1;
            end
            @(negedge clk);
            start = 1'b0;
            chk(mem_req && mem_addr == ea && mem_size == w && !done,
                dbl ? "R9" : "R6", mem_addr, ea);
         end
         mem_valid = 1'b1; mem_rdata = d; mem_err = e;
         @(negedge clk);
         mem_valid = 1'b0; mem_err = 1'b0;
         chk(!mem_req && !busy, "R6", {62'd0, mem_req, busy}, 64'd0);
         if (e)
            chk(done && exc && exc_cause == 4'd1, "R8",
                {56'd0, done, exc, 2'b0, exc_cause}, {56'd0, 8'b11000001});
         else
            chk(done && !exc && target == exp_tgt(d, w), "R7", target, exp_tgt(d, w));
      end
      @(negedge clk);
      chk(!done && !exc, "R10", {62'd0, done, exc}, 64'd0);
   endtask

   initial begin
      repeat (2000000) @(posedge clk);
      if (!finished) begin
         n_checks++; n_errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      logic [63:0] t;
      int s;
      s = $urandom(1234);
      #(CLK_PERIOD*2 + 1);
      chk(!done && !exc && !busy && !mem_req, "R1",
          {60'd0, done, exc, busy, mem_req}, 64'd0);
      @(negedge clk); rst_n = 1'b1;
      // Directed corners
      run_op(8'd0,   64'h0000_0000_1234_5640, 1'b0, 1'b1, 4'd0, 64'hffff_ffff_8765_4321, 1'b0, 0, 0);
      run_op(8'd255, 64'h1111_2222_3333_4440, 1'b1, 1'b1, 4'd0, 64'hdead_beef_0000_0001, 1'b0, 2, 0);
      run_op(8'd255, 64'hffff_ffff_ffff_ffc0, 1'b0, 1'b1, 4'd0, 64'h0000_0000_ffff_ffff, 1'b0, 1, 0);
      run_op(8'd7,   64'h0000_0000_0000_1003, 1'b0, 1'b0, 4'd9, 64'd0, 1'b0, 0, 0);
      run_op(8'd7,   64'h0000_0000_0000_1003, 1'b1, 1'b1, 4'd0, 64'd0, 1'b0, 0, 0);
      run_op(8'd7,   64'h0000_0000_0000_1000, 1'b1, 1'b0, 4'd15, 64'd0, 1'b0, 0, 0);
      run_op(8'd3,   64'h0000_0000_0000_2000, 1'b1, 1'b1, 4'd0, 64'h55, 1'b1, 1, 0);
      run_op(8'd9,   64'h0000_0000_0000_4000, 1'b0, 1'b1, 4'd0, 64'h77, 1'b0, 3, 1);
      // Random mix
      for (int n = 0; n < 400; n++) begin
         t = {$urandom, $urandom};
         if ($urandom_range(0, 3) != 0) t[5:0] = 6'd0;
         run_op(8'($urandom), t, 1'($urandom), ($urandom_range(0, 7) != 0),
                4'($urandom), {$urandom, $urandom}, ($urandom_range(0, 7) == 0),
                $urandom_range(0, 3), ($urandom_range(0, 5) == 0));
      end
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule